// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-side controller of a 32-bit synchronous burst memory. A 16-bit configuration register holds four settings: how many clock edges pass before the first word, how many clocks each word stays on the bus, whether the ready flag is driven for the current cycle or one cycle ahead, and how many words a burst returns. A pulse on the address-latch strobe, while the chip select is high, captures a start address. After the programmed initial delay the sequencer places words from consecutive addresses on the output bus. A ready flag marks each cycle in which the bus holds a valid word.

The internal store is arranged in groups of four words. A burst that starts on a group boundary streams straight through. A burst that starts inside a group pays a fixed refill delay each time it steps into a new group. During that delay the bus holds the last word and the ready flag is low. Dropping the chip select stops any burst at the next clock edge.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset the configuration reads 0x180A (latency 3, one clock per word, ready for the current cycle, 8 words), the ready flag is low and the data bus is zero.
- R2: Byte lane k (k = 0..3, lane 0 in bits 7:0) of the word at address a equals (a[7:0] + 64*k mod 256) XOR 0xC3. The words of a burst come from ascending addresses, modulo 2^AW.
- R3: With latency code L (bits 13:11, L = 2..7), the first word of a burst is on the bus after the L-th rising edge that follows the edge where the strobe was latched. The bus is flagged invalid in every cycle before that.
- R4: Bit 9 set to 0 puts a new word on the bus every clock. Bit 9 set to 1 keeps each word on the bus for two clocks, valid in both.
- R5: Length code 001 (bits 2:0) gives 4 words and code 010 gives 8 words. After the last word the bus is invalid and keeps that word.
- R6: With bit 8 set to 0 the ready flag is high exactly in the cycles where the bus holds a valid word. With bit 8 set to 1 the flag is high exactly in the cycles that precede such a cycle.
- R7: A burst whose start address has bits 1:0 equal to 00 has no invalid cycle between its first and last word.
- R8: In a burst whose start address has bits 1:0 not equal to 00, each step to an address with bits 1:0 equal to 00 is preceded by exactly 2 invalid cycles, with the bus holding the previous word.
- R9: A configuration write whose latency code is 0 or 1, or whose length code is neither 001 nor 010, leaves the whole register unchanged.
- R10: Bits 15:14, 10 and 7:4 always read 0. Bit 3 (no-wrap) always reads 1, whatever is written.
- R11: With the chip select low at a clock edge, the bus is invalid after that edge, any burst in progress ends, and a strobe in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration register contents |
| sel | input | 1 | Chip select, active high |
| adv | input | 1 | Address-latch strobe |
| addr | input | AW (10) | Start word address |
| q_data | output | 32 | Output data bus |
| q_rdy | output | 1 | Data-ready flag |

## Verification
The bench aims at bursts that start just before a group boundary and at a burst that wraps from the top of the address space into group 0. An off-by-one in the boundary test would show up as a wait in an aligned burst or a missing wait in an unaligned one. It tests both latency extremes and both word spacings, where a miscounted counter shifts every word by one clock. It also checks the look-ahead ready mode across penalty gaps, where a flag that does not lead the bus by one cycle would point at the held word. Illegal writes must leave the readback unchanged, and a strobe sent with the chip select low must not start a burst.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_BEAT, ST_PEN} brs_state_e;

  localparam int CFG_W      = 16;
  localparam int LAT_LO     = 11;
  localparam int SPACE_BIT  = 9;
  localparam int EARLY_BIT  = 8;
  localparam int LEN_LO     = 0;
  localparam int GROUP_BITS = 2;
  localparam int PEN_CYC    = 2;

  localparam logic [2:0] LEN4_CODE = 3'b001;
  localparam logic [2:0] LEN8_CODE = 3'b010;
endpackage

// File: rtl/brs_cfg.sv
`timescale 1ns/1ps
module brs_cfg
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [2:0]       lat,
  output logic             space2,
  output logic             early,
  output logic [3:0]       len_words,
  output logic [CFG_W-1:0] rdata
);
  logic [2:0] lat_q, lat_d;
  logic       sp_q, sp_d;
  logic       er_q, er_d;
  logic [2:0] len_q, len_d;
  logic       lat_ok, len_ok, take;
  logic       unused_rsvd;

  assign unused_rsvd = ^{wdata[15:14], wdata[10], wdata[7:3]};

  always_comb begin
    lat_ok = wdata[LAT_LO +: 3] >= 3'd2;
    len_ok = (wdata[LEN_LO +: 3] == LEN4_CODE) || (wdata[LEN_LO +: 3] == LEN8_CODE);
    take   = we && lat_ok && len_ok;
    lat_d  = take ? wdata[LAT_LO +: 3] : lat_q;
    sp_d   = take ? wdata[SPACE_BIT]   : sp_q;
    er_d   = take ? wdata[EARLY_BIT]   : er_q;
    len_d  = take ? wdata[LEN_LO +: 3] : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 3'd3;
      sp_q  <= 1'b0;
      er_q  <= 1'b0;
      len_q <= LEN8_CODE;
    end else if (take) begin
      lat_q <= lat_d;
      sp_q  <= sp_d;
      er_q  <= er_d;
      len_q <= len_d;
    end
  end

  assign lat       = lat_q;
  assign space2    = sp_q;
  assign early     = er_q;
  assign len_words = (len_q == LEN4_CODE) ? 4'd4 : 4'd8;
  assign rdata     = {2'b00, lat_q, 1'b0, sp_q, er_q, 4'b0000, 1'b1, len_q};
endmodule

// File: rtl/brs_store.sv
`timescale 1ns/1ps
module brs_store #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  localparam int LANES = DW / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word[8*k +: 8] = (addr[7:0] + 8'(64 * k)) ^ 8'hC3;
  end

  if (AW > 8) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^addr[AW-1:8];
  end
endmodule

// File: rtl/brs_ctrl.sv
`timescale 1ns/1ps
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          adv,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    lat,
  input  logic          space2,
  input  logic [3:0]    len_words,
  output logic [AW-1:0] fetch_addr,
  input  logic [DW-1:0] fetch_word,
  output logic [DW-1:0] bus_data,
  output logic          bus_vld,
  output logic          nxt_vld
);
  brs_state_e    st_q, st_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [AW-1:0] ad_q, ad_d, ad_inc;
  logic [3:0]    left_q, left_d;
  logic          unal_q, unal_d;
  logic          sp_q, sp_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q;
  logic          load;
  logic [2:0]    beat_cnt;

  assign ad_inc   = ad_q + AW'(1);
  assign beat_cnt = sp_q ? 3'd2 : 3'd1;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; ad_d = ad_q; left_d = left_q;
    unal_d = unal_q; sp_d = sp_q; vld_d = vld_q;
    load = 1'b0; fetch_addr = ad_q;
    if (!sel) begin
      st_d  = ST_IDLE;
      vld_d = 1'b0;
    end else if (adv) begin
      st_d   = ST_LAT;
      cnt_d  = lat;
      ad_d   = addr;
      left_d = len_words;
      unal_d = |addr[GROUP_BITS-1:0];
      sp_d   = space2;
      vld_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_LAT, ST_PEN: begin
          if (cnt_q == 3'd1) begin
            load = 1'b1; vld_d = 1'b1; st_d = ST_BEAT;
            cnt_d = beat_cnt; left_d = left_q - 4'd1;
          end else begin
            cnt_d = cnt_q - 3'd1;
          end
        end
        ST_BEAT: begin
          if (cnt_q > 3'd1) begin
            cnt_d = cnt_q - 3'd1;
          end else if (left_q == 4'd0) begin
            st_d = ST_IDLE; vld_d = 1'b0;
          end else if (unal_q && (ad_inc[GROUP_BITS-1:0] == '0)) begin
            st_d = ST_PEN; cnt_d = 3'(PEN_CYC); ad_d = ad_inc; vld_d = 1'b0;
          end else begin
            load = 1'b1; fetch_addr = ad_inc; ad_d = ad_inc; vld_d = 1'b1;
            cnt_d = beat_cnt; left_d = left_q - 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ad_q   <= '0;
      left_q <= '0;
      unal_q <= 1'b0;
      sp_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ad_q   <= ad_d;
      left_q <= left_d;
      unal_q <= unal_d;
      sp_q   <= sp_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (load) dat_q <= fetch_word;
  end

  assign bus_data = dat_q;
  assign bus_vld  = vld_q;
  assign nxt_vld  = vld_d;
endmodule

// File: rtl/burst_rd_seq.sv
`timescale 1ns/1ps
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             sel,
  input  logic             adv,
  input  logic [AW-1:0]    addr,
  output logic [DW-1:0]    q_data,
  output logic             q_rdy
);
  logic          rs_meta, rs_n;
  logic [2:0]    lat;
  logic          space2, early;
  logic [3:0]    len_words;
  logic [AW-1:0] fetch_addr;
  logic [DW-1:0] fetch_word;
  logic          bus_vld, nxt_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  brs_cfg u_cfg (
    .clk(clk), .rst_n(rs_n), .we(cfg_we), .wdata(cfg_wdata),
    .lat(lat), .space2(space2), .early(early), .len_words(len_words),
    .rdata(cfg_rdata)
  );

  brs_store #(.AW(AW), .DW(DW)) u_store (
    .addr(fetch_addr), .word(fetch_word)
  );

  brs_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rs_n), .sel(sel), .adv(adv), .addr(addr),
    .lat(lat), .space2(space2), .len_words(len_words),
    .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .bus_data(q_data), .bus_vld(bus_vld), .nxt_vld(nxt_vld)
  );

  assign q_rdy = early ? nxt_vld : bus_vld;
endmodule

// File: rtl/brs_chk.sv
`timescale 1ns/1ps
module brs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [15:0] cfg_rdata,
  input logic        sel,
  input logic        adv,
  input logic        bus_vld,
  input logic        q_rdy
);
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !bus_vld);

  assert_latch_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && adv) |=> !bus_vld);

  assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_rdata & 16'hC4F0) == 16'h0000) && cfg_rdata[3]);

  assert_legal_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[13:11] >= 3'd2) && ((cfg_rdata[2:0] == 3'b001) || (cfg_rdata[2:0] == 3'b010)));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  assert_early_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[8] && q_rdy) |=> bus_vld);
endmodule

bind burst_rd_seq brs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .sel(sel), .adv(adv), .bus_vld(bus_vld), .q_rdy(q_rdy)
);

// File: tb/sim_burst_rd_seq.sv
`timescale 1ns/1ps
module sim_burst_rd_seq;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [15:0]   cfg_wdata;
  logic [15:0]   cfg_rdata;
  logic          sel, adv;
  logic [AW-1:0] addr;
  logic [DW-1:0] q_data;
  logic          q_rdy;

  int nchk = 0;
  int nfail = 0;

  int ev[$];
  int ea[$];
  int cur_v = 0;
  int cur_a = -1;

  int m_lat = 3, m_sp = 0, m_early = 0, m_len = 8;
  logic [15:0] m_cfg = 16'h180A;

  always #2.5 clk = ~clk;

  burst_rd_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sel(sel), .adv(adv), .addr(addr),
    .q_data(q_data), .q_rdy(q_rdy)
  );

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = (8'(a) + 8'(64 * k)) ^ 8'hC3;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input int start);
    int prev = -1;
    ev.delete(); ea.delete();
    for (int i = 1; i < m_lat; i++) begin ev.push_back(0); ea.push_back(-1); end
    for (int w = 0; w < m_len; w++) begin
      int a = (start + w) % (1 << AW);
      if (w > 0 && (start % 4) != 0 && (a % 4) == 0)
        for (int p = 0; p < 2; p++) begin ev.push_back(0); ea.push_back(prev); end
      for (int s = 0; s <= m_sp; s++) begin ev.push_back(1); ea.push_back(a); end
      prev = a;
    end
  endtask

  task automatic compare(input string tag);
    int er;
    er = (m_early != 0) ? ((ev.size() > 0) ? ev[0] : 0) : cur_v;
    chk(q_rdy == 1'(er), {tag, " ready"}, 32'(q_rdy), 32'(er));
    if (cur_a >= 0)
      chk(q_data == exp_word(cur_a), {tag, " R2 data"}, q_data, exp_word(cur_a));
  endtask

  task automatic step(input logic a_adv, input logic a_sel, input int a_addr, input string tag);
    sel = a_sel; adv = a_adv; addr = AW'(a_addr);
    @(posedge clk);
    if (!a_sel) begin
      ev.delete(); ea.delete(); cur_v = 0; cur_a = -1;
    end else if (a_adv) begin
      build(a_addr); cur_v = 0; cur_a = -1;
    end else if (ev.size() > 0) begin
      cur_v = ev.pop_front(); cur_a = ea.pop_front();
    end else begin
      cur_v = 0; cur_a = -1;
    end
    #1 adv = 1'b0;
    #1 compare(tag);
  endtask

  task automatic burst(input int start, input string tag);
    int n;
    step(1'b1, 1'b1, start, tag);
    n = ev.size() + 2;
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 0, tag);
  endtask

  task automatic cfgw(input logic [15:0] v, input string tag);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk);
    if (v[13:11] >= 3'd2 && (v[2:0] == 3'b001 || v[2:0] == 3'b010)) begin
      m_lat = int'(v[13:11]); m_sp = int'(v[9]); m_early = int'(v[8]);
      m_len = (v[2:0] == 3'b001) ? 4 : 8;
      m_cfg = {2'b00, v[13:11], 1'b0, v[9], v[8], 4'b0000, 1'b1, v[2:0]};
    end
    #1 cfg_we = 1'b0;
    #1 chk(cfg_rdata == m_cfg, {tag, " cfg readback"}, 32'(cfg_rdata), 32'(m_cfg));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; sel = 1'b0; adv = 1'b0; addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(cfg_rdata == 16'h180A, "R1 reset cfg", 32'(cfg_rdata), 32'h180A);
    chk(q_rdy == 1'b0, "R1 reset ready", 32'(q_rdy), 0);
    chk(q_data == '0, "R1 reset data", q_data, 0);

    step(1'b0, 1'b1, 0, "R11 idle");
    burst(16'h010, "R7 aligned L3");
    burst(16'h005, "R8 unaligned L3");

    cfgw(16'h2A01, "R4 cfg L5 sp2 len4");
    burst(16'h020, "R4 R5 aligned sp2");
    burst(16'h022, "R5 R8 unaligned sp2");

    cfgw(16'h0802, "R9 lat1");
    cfgw(16'h2003, "R9 len3");
    cfgw(16'h3000, "R9 len0");
    burst(16'h030, "R9 unchanged burst");

    cfgw(16'hFCF2, "R10 reserved");
    burst(16'h3FE, "R3 L7 top wrap");

    cfgw(16'h1102, "R6 cfg L2 early");
    burst(16'h007, "R6 early unaligned");
    burst(16'h040, "R6 R7 early aligned");
    cfgw(16'h1302, "R6 cfg early sp2");
    burst(16'h0C3, "R6 early sp2 unaligned");

    cfgw(16'h1802, "R11 cfg");
    step(1'b1, 1'b1, 16'h030, "R11 latch");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0, "R11 run");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 0, "R11 abort");
    step(1'b1, 1'b0, 16'h050, "R11 strobe ignored");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 0, "R11 stays idle");
    burst(16'h061, "R11 restart");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule